// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate Controller

This block sits between a host's active-low chip enable and a battery-backed low-power SRAM. While the supply is healthy it passes the chip enable through, after input synchronisation. When a digitised supply-monitor flag reports an out-of-tolerance supply, the block deselects the memory so that no write can land while the rails are collapsing. An access that is already under way is allowed to finish first. A timeout bounds how long that can take, and when it expires the memory is deselected regardless.

When the fail flag clears, the memory is held deselected for a long recovery window. This lets the host settle before it may touch the SRAM again. A second comparator flag, which reports that the supply has dropped below the battery switchover level, drives a supply-select output that picks the battery or the main rail. A strap input that picks one of two trip levels is forwarded to the comparator as a registered select bit. A status output reports when the block is forcing the memory deselected.

Top module: `pfgate_ctrl`

## Requirements
- R1: With the supply valid and no hold active, `ce_n_out` equals `ce_n_in` with a latency of two clock edges.
- R2: When `pwr_fail_in` rises while `ce_n_in` is high, `ce_n_out` is high and `prot_active_out` is 1 three edges later. Afterwards `ce_n_out` stays high whatever `ce_n_in` does.
- R3: When `pwr_fail_in` rises while `ce_n_in` is low, `ce_n_out` keeps following `ce_n_in` until the access ends (`ce_n_in` returns high). From then on `ce_n_out` stays high.
- R4: If the access in progress has not ended within `WP_CYCLES` cycles of entering the drain phase, `ce_n_out` is forced high and protection starts. With the chip enable held low from before the fail, `ce_n_out` is still low 2+`WP_CYCLES` edges after the fail input rises and is high one edge later.
- R5: After `pwr_fail_in` falls, `ce_n_out` stays high for `REC_CYCLES` cycles and ignores `ce_n_in`. With the chip enable held low, `ce_n_out` returns low exactly 3+`REC_CYCLES` edges after the fall.
- R6: A new rise of `pwr_fail_in` during recovery returns the block to protection. The full recovery window restarts on the next fall.
- R7: `batt_sel_out` (1 = battery, 0 = main supply) equals `below_so_in` with a latency of two edges, independent of the chip enable.
- R8: `thr_sel_out` is a one-edge registered copy of `thr_sel_in` (0 = upper trip level, 1 = lower trip level).
- R9: During and after reset the block is in recovery: `ce_n_out`=1, `prot_active_out`=1, `batt_sel_out`=0, `thr_sel_out`=0.
- R10: `prot_active_out` is 1 exactly while the output is forced high (protection or recovery), and 0 in pass-through and in the drain phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_in | input | 1 | Host chip enable, active low, asynchronous |
| pwr_fail_in | input | 1 | Supply out of tolerance flag, asynchronous |
| below_so_in | input | 1 | Supply below switchover level flag, asynchronous |
| thr_sel_in | input | 1 | Trip level strap |
| ce_n_out | output | 1 | Conditioned chip enable to the SRAM, active low |
| prot_active_out | output | 1 | Memory is being forced deselected |
| batt_sel_out | output | 1 | Supply select, 1 = battery |
| thr_sel_out | output | 1 | Trip level select to the comparator |

## Verification
The hardest situation to reach from the ports is a power-fail that arrives again in the middle of the recovery window. Reaching it requires a complete fail, drain, protect and release sequence first. The stimulus releases the fail flag, waits a few cycles inside recovery, raises the flag again and releases it. It then samples one edge before the point where a fresh window would end. A design that resumed its old count would already be in pass-through there. The drain timeout is reached in a similar way: the chip enable is held low across the fail edge, and the output is sampled on both sides of the expiry edge.

// File: rtl/pfgate_pkg.sv
package pfgate_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfg_state_e;

  // the memory is held deselected in these states
  function automatic logic is_forced(pfg_state_e s);
    return (s == ST_PROTECT) || (s == ST_RECOVER);
  endfunction

  // conditioned enable for a given state and synchronised host enable
  function automatic logic gate_ce(pfg_state_e s, logic ce_n_sync);
    return is_forced(s) ? 1'b1 : ce_n_sync;
  endfunction

endpackage

// File: rtl/pfgate_sync.sv
module pfgate_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfgate_timer.sv
module pfgate_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // counts cycles spent with run high; cleared whenever run is low
  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pfgate_ctrl.sv
module pfgate_ctrl
  import pfgate_pkg::*;
#(
  parameter int WP_CYCLES   = 10000,
  parameter int REC_CYCLES  = 10000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_in,
  input  logic pwr_fail_in,
  input  logic below_so_in,
  input  logic thr_sel_in,
  output logic ce_n_out,
  output logic prot_active_out,
  output logic batt_sel_out,
  output logic thr_sel_out
);
  localparam int SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b001; // enable idle, flags clear

  logic [SYNC_W-1:0] raw_vec, sync_vec;
  logic ce_s, pf_s, so_s;
  logic wp_done, rec_done;
  logic thr_q;
  pfg_state_e st_q, st_d;

  assign raw_vec = {below_so_in, pwr_fail_in, ce_n_in};

  pfgate_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(sync_vec)
  );

  assign ce_s = sync_vec[0];
  assign pf_s = sync_vec[1];
  assign so_s = sync_vec[2];

  pfgate_timer #(.LIMIT(WP_CYCLES)) wp_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_DRAIN), .done(wp_done)
  );

  pfgate_timer #(.LIMIT(REC_CYCLES)) rec_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_RECOVER), .done(rec_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL:  if (pf_s) st_d = ce_s ? ST_PROTECT : ST_DRAIN;
      ST_DRAIN:   if (ce_s || wp_done) st_d = ST_PROTECT;
      ST_PROTECT: if (!pf_s) st_d = ST_RECOVER;
      ST_RECOVER: begin
        if (pf_s)          st_d = ST_PROTECT;
        else if (rec_done) st_d = ST_NORMAL;
      end
      default:    st_d = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_RECOVER;
      thr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      thr_q <= thr_sel_in;
    end
  end

  assign ce_n_out        = gate_ce(st_q, ce_s);
  assign prot_active_out = is_forced(st_q);
  assign batt_sel_out    = so_s;
  assign thr_sel_out     = thr_q;
endmodule

// File: rtl/pfgate_chk.sv
module pfgate_chk
  import pfgate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pfg_state_e st_q,
  input logic       ce_s,
  input logic       pf_s,
  input logic       wp_done,
  input logic       rec_done,
  input logic       ce_n_out,
  input logic       prot_active_out
);
  // R2: fail seen with idle enable deselects on the next cycle
  p_idle_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && pf_s && ce_s) |=> (ce_n_out && prot_active_out));

  // R3: fail seen during an access keeps the enable following the host
  p_drain_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && pf_s && !ce_s) |=> (!prot_active_out && ce_n_out == ce_s));

  // R4: timeout expiry forces protection
  p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && wp_done) |=> (ce_n_out && prot_active_out));

  // R5: fail release from protection starts a hold, not pass-through
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROTECT && !pf_s) |=> (ce_n_out && prot_active_out));

  // R5: pass-through never resumes before the hold count completes
  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && !rec_done) |=> prot_active_out);

  // R6: fail during hold returns to protection
  p_refail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && pf_s) |=> (st_q == ST_PROTECT));

  // R10: status high always means the enable is deasserted
  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active_out |-> ce_n_out);
endmodule

bind pfgate_ctrl pfgate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .st_q(st_q), .ce_s(ce_s), .pf_s(pf_s),
  .wp_done(wp_done), .rec_done(rec_done),
  .ce_n_out(ce_n_out), .prot_active_out(prot_active_out)
);

// File: tb/pfgate_ctrl_tb_top.sv
module pfgate_ctrl_tb_top;
  localparam int WP  = 12;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n_in = 1'b1, pwr_fail_in = 1'b0, below_so_in = 1'b0, thr_sel_in = 1'b0;
  logic ce_n_out, prot_active_out, batt_sel_out, thr_sel_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  pfgate_ctrl #(.WP_CYCLES(WP), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n_in(ce_n_in), .pwr_fail_in(pwr_fail_in),
    .below_so_in(below_so_in), .thr_sel_in(thr_sel_in), .ce_n_out(ce_n_out),
    .prot_active_out(prot_active_out), .batt_sel_out(batt_sel_out),
    .thr_sel_out(thr_sel_out)
  );

  // sig: 0 = ce_n_out, 1 = prot_active_out, 2 = batt_sel_out, 3 = thr_sel_out
  typedef struct {
    int    sig;
    logic  exp;
    string tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      chk_ev;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_sig(int sig, logic exp, string tag);
    exp_item_t it;
    it.sig = sig; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic act;
        it = sb_q.pop_front();
        case (it.sig)
          0: act = ce_n_out;
          1: act = prot_active_out;
          2: act = batt_sel_out;
          default: act = thr_sel_out;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%0b expected=%0b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    pat = 8'b1011_0010;
    tick(3);
    expect_sig(0, 1'b1, "R9 reset ce_n_out");
    expect_sig(1, 1'b1, "R9 reset status");
    expect_sig(2, 1'b0, "R9 reset batt_sel");
    expect_sig(3, 1'b0, "R9 reset thr_sel");
    rst_n = 1'b1;
    ce_n_in = 1'b0;
    tick(5);
    expect_sig(0, 1'b1, "R5 hold after reset ignores enable");
    expect_sig(1, 1'b1, "R10 status during hold");
    tick(REC + 2);
    expect_sig(0, 1'b0, "R1 pass-through after hold");
    expect_sig(1, 1'b0, "R10 status in pass-through");

    for (int i = 0; i < 8; i++) begin
      ce_n_in = pat[i];
      tick(2);
      expect_sig(0, pat[i], "R1 follow pattern");
    end
    ce_n_in = 1'b1;
    tick(2);

    // R2: fail with idle enable
    pwr_fail_in = 1'b1;
    tick(3);
    expect_sig(0, 1'b1, "R2 forced high");
    expect_sig(1, 1'b1, "R2 status");
    ce_n_in = 1'b0;
    tick(4);
    expect_sig(0, 1'b1, "R2 enable ignored");

    // R5: exact hold length
    pwr_fail_in = 1'b0;
    tick(3 + REC - 1);
    expect_sig(0, 1'b1, "R5 still held at last cycle");
    expect_sig(1, 1'b1, "R5 status at last cycle");
    tick(1);
    expect_sig(0, 1'b0, "R5 released after window");
    expect_sig(1, 1'b0, "R5 status cleared");

    // R3: fail during access, access ends normally
    pwr_fail_in = 1'b1;
    tick(3);
    expect_sig(0, 1'b0, "R3 access continues");
    expect_sig(1, 1'b0, "R10 status low while draining");
    tick(3);
    expect_sig(0, 1'b0, "R3 access still continues");
    ce_n_in = 1'b1;
    tick(2);
    expect_sig(0, 1'b1, "R3 access ended");
    tick(1);
    expect_sig(1, 1'b1, "R3 protection after access");
    ce_n_in = 1'b0;
    tick(3);
    expect_sig(0, 1'b1, "R3 new access blocked");

    pwr_fail_in = 1'b0;
    ce_n_in = 1'b1;
    tick(REC + 10);
    expect_sig(1, 1'b0, "R5 back to pass-through");

    // R4: access never ends, timeout forces protection
    ce_n_in = 1'b0;
    tick(3);
    pwr_fail_in = 1'b1;
    tick(3 + WP - 1);
    expect_sig(0, 1'b0, "R4 before timeout");
    tick(1);
    expect_sig(0, 1'b1, "R4 forced at timeout");
    expect_sig(1, 1'b1, "R4 status at timeout");

    // R6: refail inside the hold window restarts it
    pwr_fail_in = 1'b0;
    tick(3 + 5);
    expect_sig(1, 1'b1, "R6 inside hold");
    pwr_fail_in = 1'b1;
    tick(3);
    expect_sig(0, 1'b1, "R6 refail protected");
    pwr_fail_in = 1'b0;
    tick(3 + REC - 1);
    expect_sig(1, 1'b1, "R6 window restarted");
    tick(1);
    expect_sig(1, 1'b0, "R6 release after full window");
    expect_sig(0, 1'b0, "R6 pass-through resumes");

    // R7: supply select
    below_so_in = 1'b1;
    ce_n_in = 1'b1;
    tick(1);
    expect_sig(2, 1'b0, "R7 latency one edge");
    tick(1);
    expect_sig(2, 1'b1, "R7 battery selected");
    below_so_in = 1'b0;
    tick(2);
    expect_sig(2, 1'b0, "R7 main supply selected");

    // R8: trip level forwarding
    thr_sel_in = 1'b1;
    tick(1);
    expect_sig(3, 1'b1, "R8 lower trip select");
    thr_sel_in = 1'b0;
    tick(1);
    expect_sig(3, 1'b0, "R8 upper trip select");

    tick(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule